// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block regulates the peak current in one H-bridge winding. It drives the four gate enables of the bridge: a high-side and a low-side switch on each of the two legs. While it drives, it keeps the diagonal pair chosen by the direction input switched on. When the current comparator reports that the winding current is above the trip level, it starts a one-shot off-time of programmable length. That off-time opens with a programmable stretch of fast decay, in which the opposite diagonal conducts. The rest of the off-time is slow decay, with both low-side switches on. When the off-time ends, drive resumes and the comparator is ignored for a blanking interval.

A change of direction forces every switch off for a programmable crossover interval. The new pair then starts, behind a fresh blanking interval. Dropping the enable turns the bridge off at once. Raising it again restarts drive with blanking. All lengths are counts of the system clock. The comparator flag passes through a two-stage synchronizer before the controller uses it. An interlock keeps the two switches of a leg from being on together. The analog sensing and the trip-level DAC are outside the block.

Top module: `offtime_chopper`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all four gate enables are 0. Bit layout of `gates_o`: [3] leg A high, [2] leg A low, [1] leg B high, [0] leg B low.
- R2: While driving, `gates_o` shows the drive pair: 4'b1001 when the latched direction is 1, and 4'b0110 when it is 0.
- R3: The comparator flag is registered twice before use. If the synchronized flag is high while the controller is driving (not blanking), the next state is the off-time.
- R4: The off-time lasts max(`off_len_i`,1) clock cycles. After it, the controller re-enters drive through blanking.
- R5: The first min(`fast_len_i`, off-time) cycles of the off-time target the opposite diagonal, which is the drive pair of the inverted direction. `fast_len_i`=0 gives pure slow decay. `fast_len_i` ≥ `off_len_i` gives pure fast decay.
- R6: The remaining off-time cycles target both low sides, 4'b0101.
- R7: After each off-time, after each crossover and after each enable, the drive pair is on for max(`blank_len_i`,1) cycles with the comparator ignored.
- R8: When `dir_i` differs from the latched direction while enabled, from any state including the off-time, the target is all-off for max(`dead_len_i`,1) cycles. The new direction is then latched, and blanking follows.
- R9: `en_i`=0 puts the controller in idle at the next edge. In idle the gates are all off.
- R10: The two switches of a leg are never on together. When the new target would turn on a switch whose leg partner is currently on, the gates first take, for one cycle, the bitwise AND of the current and the new pattern.
- R11: A comparator trip seen only during blanking is discarded and does not start an off-time later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Requested current direction |
| en_i | input | 1 | Drive enable, 0 when the current code is all-zero |
| trip_i | input | 1 | Asynchronous comparator flag, 1 when current exceeds trip |
| off_len_i | input | CNT_W | Off-time length in cycles |
| fast_len_i | input | CNT_W | Fast-decay cycles at the start of the off-time |
| blank_len_i | input | CNT_W | Blanking length in cycles |
| dead_len_i | input | CNT_W | Crossover dead-time length in cycles |
| gates_o | output | 4 | Gate enables {A high, A low, B high, B low} |

## Verification
The gate pattern is a registered view of the controller state, so a wrong state or a wrong count shows on `gates_o` in the next cycle. A miscounted off-time moves the return to the drive pair by the size of the error. A lost blanking shows as an early drop to a decay pattern three cycles after a comparator pulse. A broken interlock shows as a missing intermediate pattern between drive and decay. The bench holds a cycle-accurate reference model and compares the full gate vector with it on every clock, so any divergence is reported in the cycle where it first reaches the ports.

// File: rtl/chop_pkg.sv
package chop_pkg;

  localparam int CALC_W = 17;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XOVER,
    ST_BLANK,
    ST_DRIVE,
    ST_OFFT
  } chop_st_e;

  localparam logic [3:0] SLOW_PAT = 4'b0101;

  // diagonal pair conducting for a given direction
  function automatic logic [3:0] drive_pat(input logic dir);
    return dir ? 4'b1001 : 4'b0110;
  endfunction

  // each bit moved onto the position of its leg partner
  function automatic logic [3:0] leg_partner(input logic [3:0] g);
    return {g[2], g[3], g[0], g[1]};
  endfunction

  // one-cycle overlap step when a leg would flip
  function automatic logic [3:0] interlock(input logic [3:0] prev, input logic [3:0] nxt);
    return ((nxt & leg_partner(prev)) != 4'b0000) ? (prev & nxt) : nxt;
  endfunction

  // a span of length len (0 treated as 1) ends in the cycle with index el
  function automatic logic span_done(input logic [CALC_W-1:0] el, input logic [CALC_W-1:0] len);
    logic [CALC_W-1:0] eff;
    eff = (len == '0) ? CALC_W'(1) : len;
    return (el + CALC_W'(1)) >= eff;
  endfunction

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/chop_seq.sv
module chop_seq
  import chop_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             dir_i,
  input  logic             trip_s_i,
  input  logic [CNT_W-1:0] off_len_i,
  input  logic [CNT_W-1:0] fast_len_i,
  input  logic [CNT_W-1:0] blank_len_i,
  input  logic [CNT_W-1:0] dead_len_i,
  output chop_st_e         st_o,
  output logic [3:0]       tgt_o,
  output logic             fast_ph_o
);
  localparam int CW = CALC_W;

  chop_st_e         st_q, st_d;
  logic [CNT_W-1:0] el_q, el_d;
  logic             dir_q, dir_d;
  logic [CNT_W-1:0] len_sel;

  // named internal events
  logic dir_chg, span_end, trip_evt, fast_ph;

  assign dir_chg  = (dir_i != dir_q);
  assign trip_evt = (st_q == ST_DRIVE) && trip_s_i;
  assign fast_ph  = (st_q == ST_OFFT) && (el_q < fast_len_i);

  always_comb begin
    case (st_q)
      ST_BLANK: len_sel = blank_len_i;
      ST_OFFT:  len_sel = off_len_i;
      ST_XOVER: len_sel = dead_len_i;
      default:  len_sel = '0;
    endcase
  end

  assign span_end = span_done(CW'(el_q), CW'(len_sel));

  always_comb begin
    st_d  = st_q;
    el_d  = el_q;
    dir_d = dir_q;
    if (st_q == ST_IDLE) begin
      dir_d = dir_i;
      if (en_i) begin
        st_d = ST_BLANK;
        el_d = '0;
      end
    end else if (!en_i) begin
      st_d = ST_IDLE;
      el_d = '0;
    end else if (dir_chg) begin
      st_d  = ST_XOVER;
      el_d  = '0;
      dir_d = dir_i;
    end else begin
      case (st_q)
        ST_XOVER, ST_OFFT: begin
          if (span_end) begin
            st_d = ST_BLANK;
            el_d = '0;
          end else el_d = el_q + 1'b1;
        end
        ST_BLANK: begin
          if (span_end) begin
            st_d = ST_DRIVE;
            el_d = '0;
          end else el_d = el_q + 1'b1;
        end
        ST_DRIVE: begin
          if (trip_evt) begin
            st_d = ST_OFFT;
            el_d = '0;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      el_q  <= '0;
      dir_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      el_q  <= el_d;
      dir_q <= dir_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_BLANK, ST_DRIVE: tgt_o = drive_pat(dir_q);
      ST_OFFT:            tgt_o = fast_ph ? drive_pat(~dir_q) : SLOW_PAT;
      default:            tgt_o = 4'b0000;
    endcase
  end

  assign st_o      = st_q;
  assign fast_ph_o = fast_ph;

  // R3: a synchronized trip while driving starts the off-time
  assert_trip_starts_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRIVE && trip_s_i && en_i && !dir_chg) |=> (st_q == ST_OFFT));

  // R11: blanking never leads straight into an off-time
  assert_blank_ignores_trip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BLANK) |=> (st_q != ST_OFFT));

  // R9: disable takes effect at the next edge
  assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (st_q == ST_IDLE));

  // R8: a direction change while enabled enters crossover
  assert_dir_change_xover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && st_q != ST_IDLE && dir_chg) |=> (st_q == ST_XOVER));
endmodule

// File: rtl/chop_gate.sv
module chop_gate
  import chop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] tgt_i,
  output logic [3:0] gates_o
);
  logic [3:0] g_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) g_q <= 4'b0000;
    else        g_q <= interlock(g_q, tgt_i);
  end

  assign gates_o = g_q;

  // R10: no shoot-through on either leg
  assert_leg_a_safe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(g_q[3] && g_q[2]));
  assert_leg_b_safe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(g_q[1] && g_q[0]));
endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper
  import chop_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_i,
  input  logic             en_i,
  input  logic             trip_i,
  input  logic [CNT_W-1:0] off_len_i,
  input  logic [CNT_W-1:0] fast_len_i,
  input  logic [CNT_W-1:0] blank_len_i,
  input  logic [CNT_W-1:0] dead_len_i,
  output logic [3:0]       gates_o
);
  logic       trip_s;
  chop_st_e   st;
  logic [3:0] tgt;
  logic       fast_ph;

  chop_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(trip_i), .q_o(trip_s)
  );

  chop_seq #(.CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .dir_i(dir_i), .trip_s_i(trip_s),
    .off_len_i(off_len_i), .fast_len_i(fast_len_i),
    .blank_len_i(blank_len_i), .dead_len_i(dead_len_i),
    .st_o(st), .tgt_o(tgt), .fast_ph_o(fast_ph)
  );

  chop_gate gate_i (
    .clk(clk), .rst_n(rst_n), .tgt_i(tgt), .gates_o(gates_o)
  );

  // R8: crossover holds every switch off
  assert_xover_all_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XOVER) |=> (gates_o == 4'b0000));

  // R9: idle holds every switch off
  assert_idle_all_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |=> (gates_o == 4'b0000));

  // R5: the second fast-decay cycle onward shows the reverse diagonal
  assert_fast_reverse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_ph && $past(fast_ph)) |=> (gates_o == 4'b0110 || gates_o == 4'b1001));
endmodule

// File: tb/offtime_chopper_tb_top.sv
`timescale 1ns/1ps
module offtime_chopper_tb_top;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_i = 1'b1, en_i = 1'b0, trip_i = 1'b0;
  logic [CNT_W-1:0] off_len = 8'd12, fast_len = 8'd4, blank_len = 8'd5, dead_len = 8'd3;
  logic [3:0] gates;

  always #2.5 clk = ~clk;

  offtime_chopper #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .en_i(en_i), .trip_i(trip_i),
    .off_len_i(off_len), .fast_len_i(fast_len), .blank_len_i(blank_len),
    .dead_len_i(dead_len), .gates_o(gates)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model: 0 idle, 1 crossover, 2 blank, 3 drive, 4 off-time
  int m_st = 0, m_el = 0;
  bit m_dir = 0, m_s1 = 0, m_s2 = 0;
  bit [3:0] m_g = 4'b0000;

  function automatic bit [3:0] pair_for(input bit d);
    if (d) return 4'b1001;   // A high + B low
    return 4'b0110;          // B high + A low
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_el = 0; m_dir = 0; m_s1 = 0; m_s2 = 0; m_g = 4'b0000;
    end else begin
      bit [3:0] want, nxt;
      bit clash, fin;
      int len;
      want = 4'b0000;
      if (m_st == 2 || m_st == 3) want = pair_for(m_dir);
      else if (m_st == 4) want = (m_el < int'(fast_len)) ? pair_for(!m_dir) : 4'b0101;
      clash = 0;
      for (int leg = 0; leg < 2; leg++) begin
        bit hi_new, lo_new, hi_old, lo_old;
        hi_new = want[2*leg+1]; lo_new = want[2*leg];
        hi_old = m_g[2*leg+1];  lo_old = m_g[2*leg];
        if ((hi_new && lo_old) || (lo_new && hi_old)) clash = 1;
      end
      nxt = clash ? (m_g & want) : want;
      len = (m_st == 2) ? int'(blank_len) : (m_st == 4) ? int'(off_len) :
            (m_st == 1) ? int'(dead_len) : 0;
      if (len < 1) len = 1;
      fin = (m_el + 1 >= len);
      if (m_st == 0) begin
        m_dir = dir_i;
        if (en_i) begin m_st = 2; m_el = 0; end
      end else if (!en_i) begin
        m_st = 0; m_el = 0;
      end else if (dir_i != m_dir) begin
        m_st = 1; m_el = 0; m_dir = dir_i;
      end else begin
        case (m_st)
          1, 4: if (fin) begin m_st = 2; m_el = 0; end else m_el++;
          2:    if (fin) begin m_st = 3; m_el = 0; end else m_el++;
          3:    if (m_s2) begin m_st = 4; m_el = 0; end
          default: ;
        endcase
      end
      m_g = nxt;
      m_s2 = m_s1; m_s1 = trip_i;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      string tag;
      case (m_st)
        0: tag = "R9";
        1: tag = "R8";
        2: tag = "R7 R11";
        3: tag = "R2 R3";
        default: tag = "R4 R5 R6";
      endcase
      checks++;
      if (gates !== m_g) begin
        errors++;
        $display("FAIL %s: gates actual=%b expected=%b at %0t", tag, gates, m_g, $time);
      end
      checks++;
      if ((gates[3] && gates[2]) || (gates[1] && gates[0])) begin
        errors++;
        $display("FAIL R10: leg overlap actual=%b expected=no overlap", gates);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trip();
    trip_i = 1'b1; run(1); trip_i = 1'b0;
  endtask

  initial begin
    run(3);
    checks++;
    if (gates !== 4'b0000) begin
      errors++; $display("FAIL R1: reset gates actual=%b expected=0000", gates);
    end
    rst_n = 1'b1;
    run(1);
    checks++;
    if (gates !== 4'b0000) begin
      errors++; $display("FAIL R1: after reset actual=%b expected=0000", gates);
    end
    run(1);
    // enable; a trip pulse inside blanking must be discarded (R11)
    en_i = 1'b1; run(3); pulse_trip(); run(12);
    // normal chop, mixed decay (R4 R5 R6)
    pulse_trip(); run(30);
    // comparator held high: repeated chopping
    trip_i = 1'b1; run(60); trip_i = 1'b0; run(10);
    // pure slow decay
    fast_len = 8'd0; pulse_trip(); run(25);
    // pure fast decay
    fast_len = 8'd20; pulse_trip(); run(25);
    fast_len = 8'd4;
    // direction change while driving (R8)
    dir_i = 1'b0; run(15);
    // direction change during the off-time aborts it
    pulse_trip(); run(5); dir_i = 1'b1; run(20);
    // disable during the off-time, then re-enable (R9)
    pulse_trip(); run(6); en_i = 1'b0; run(5); en_i = 1'b1; run(15);
    // zero-length spans
    off_len = 8'd0; fast_len = 8'd0; blank_len = 8'd0; dead_len = 8'd0;
    trip_i = 1'b1; run(20);
    for (int k = 0; k < 6; k++) begin dir_i = ~dir_i; run(3); end
    fast_len = 8'd1; off_len = 8'd1; run(15);
    trip_i = 1'b0; run(10);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule